// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A purely combinational 16-bit adder. It takes two operands and a carry input and returns a 16-bit sum and a carry output. It does not pass the carry from bit to bit. Instead it computes every carry from lookahead terms arranged in a two-level tree.

At the first level, each bit position produces a generate term (both operand bits set) and a propagate term (either operand bit set). The bits form four groups of four. Each group reduces its bit terms to a group generate and a group propagate. At the second level, a lookahead unit turns the four group term pairs and the carry input into the carry entering each group and the final carry output. Each group then expands its own internal carries from its incoming group carry as a flat sum of products. It forms each sum bit as the XOR of the two operand bits and that bit's carry.

The block has no clock and no state. It can be placed anywhere a single-cycle 16-bit addition is needed, and its outputs settle within the same cycle as its inputs.

Top module: `cla16_adder`

## Requirements
- R1: `sum` equals the low 16 bits of the unsigned total `a + b + cin`, for any operand values.
- R2: `cout` equals bit 16 of the unsigned total `a + b + cin`.
- R3: A carry produced inside one 4-bit group (bits 4k..4k+3) is delivered to the next group. For example, `a=0x000F`, `b=0x0001`, `cin=0` gives `sum=0x0010`, `cout=0`.
- R4: A group in which every bit has at least one operand bit set passes its incoming carry straight through. Examples: `a=0xFFFF`, `b=0x0000`, `cin=1` gives `sum=0x0000`, `cout=1`; `a=0xAAAA`, `b=0x5555`, `cin=1` gives the same result.
- R5: All-zero operands with `cin=0` give `sum=0x0000` and `cout=0`.
- R6: Bit positions where both operand bits are set both generate a carry and keep their own sum bit correct. Examples: `a=b=0xFFFF` gives `sum=0xFFFF`, `cout=1` when `cin=1`, and `sum=0xFFFE`, `cout=1` when `cin=0`.
- R7: `a=0x1A33`, `b=0xE5EB`, `cin=0` gives `sum=0x001E`, `cout=1`. In this case only group 1 (bits 7..4) generates, and only group 0 does not propagate.
- R8: Swapping `a` and `b` leaves `sum` and `cout` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the total |
| cout | output | 1 | Carry out of bit 15 |

## Verification
A wrong group generate or group propagate term corrupts the carry entering every higher group. The fault appears at the ports as a sum wrong in bit 4k or above, or as a wrong `cout`, and it appears in the same evaluation as the offending inputs. The fault only shows up when the group in question has to generate or pass a carry. For that reason the directed vectors force carries through every group boundary, force full-length propagation with both the OR-only and the both-set forms of propagate, and include the worked example. Random vectors then cover mixed patterns.

// File: rtl/cla16_pkg.sv
package cla16_pkg;
    localparam int GRP_W  = 4;
    localparam int GRP_N  = 4;
    localparam int ADD_W  = GRP_W * GRP_N;
    localparam int TERM_W = (GRP_W > GRP_N) ? GRP_W : GRP_N;

    typedef struct packed {
        logic gen;
        logic prop;
    } grp_pg_t;

    // Flat sum-of-products carry into position k:
    // OR over j<k of g[j] & p[j+1..k-1], plus c0 & p[0..k-1].
    function automatic logic sop_carry(input logic [TERM_W-1:0] g,
                                       input logic [TERM_W-1:0] p,
                                       input logic c0,
                                       input int k);
        logic acc;
        logic prod;
        acc  = 1'b0;
        prod = c0;
        for (int m = 0; m < TERM_W; m++) begin
            if (m < k) prod = prod & p[m];
        end
        acc = acc | prod;
        for (int j = 0; j < TERM_W; j++) begin
            if (j < k) begin
                prod = g[j];
                for (int m = 0; m < TERM_W; m++) begin
                    if (m > j && m < k) prod = prod & p[m];
                end
                acc = acc | prod;
            end
        end
        return acc;
    endfunction
endpackage

// File: rtl/cla16_bit_pg.sv
module cla16_bit_pg
    import cla16_pkg::*;
#(
    parameter int W = ADD_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] gen,
    output logic [W-1:0] prop,
    output logic [W-1:0] half
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign gen[i]  = a[i] & b[i];
        assign prop[i] = a[i] | b[i];
        assign half[i] = a[i] ^ b[i];
    end
endmodule

// File: rtl/cla16_group.sv
module cla16_group
    import cla16_pkg::*;
#(
    parameter int W = GRP_W
) (
    input  logic [W-1:0] gen,
    input  logic [W-1:0] prop,
    input  logic [W-1:0] half,
    input  logic         c_in,
    output grp_pg_t      grp,
    output logic [W-1:0] s
);
    typedef struct packed {
        logic [W-1:0] carry;
        logic         gen;
        logic         prop;
    } grp_res_t;

    grp_res_t res_d;
    logic [TERM_W-1:0] g_ext;
    logic [TERM_W-1:0] p_ext;

    always_comb begin
        g_ext = '0;
        p_ext = '0;
        g_ext[W-1:0] = gen;
        p_ext[W-1:0] = prop;
        for (int k = 0; k < W; k++) begin
            res_d.carry[k] = sop_carry(g_ext, p_ext, c_in, k);
        end
        res_d.gen  = sop_carry(g_ext, p_ext, 1'b0, W);
        res_d.prop = &prop;
    end

    assign grp.gen  = res_d.gen;
    assign grp.prop = res_d.prop;
    assign s        = half ^ res_d.carry;
endmodule

// File: rtl/cla16_lookahead.sv
module cla16_lookahead
    import cla16_pkg::*;
#(
    parameter int N = GRP_N
) (
    input  grp_pg_t [N-1:0] grp,
    input  logic            cin,
    output logic [N:0]      carry
);
    logic [TERM_W-1:0] g_ext;
    logic [TERM_W-1:0] p_ext;
    logic [N:0]        carry_d;

    always_comb begin
        g_ext = '0;
        p_ext = '0;
        for (int i = 0; i < N; i++) begin
            g_ext[i] = grp[i].gen;
            p_ext[i] = grp[i].prop;
        end
        for (int k = 0; k <= N; k++) begin
            carry_d[k] = sop_carry(g_ext, p_ext, cin, k);
        end
    end

    assign carry = carry_d;
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla16_pkg::*;
(
    input  logic [ADD_W-1:0] a,
    input  logic [ADD_W-1:0] b,
    input  logic             cin,
    output logic [ADD_W-1:0] sum,
    output logic             cout
);
    logic [ADD_W-1:0]    bit_gen;
    logic [ADD_W-1:0]    bit_prop;
    logic [ADD_W-1:0]    bit_half;
    grp_pg_t [GRP_N-1:0] grp_pg;
    logic [GRP_N:0]      grp_carry;

    cla16_bit_pg #(.W(ADD_W)) u_pg (
        .a    (a),
        .b    (b),
        .gen  (bit_gen),
        .prop (bit_prop),
        .half (bit_half)
    );

    for (genvar k = 0; k < GRP_N; k++) begin : g_grp
        cla16_group #(.W(GRP_W)) u_grp (
            .gen  (bit_gen[k*GRP_W +: GRP_W]),
            .prop (bit_prop[k*GRP_W +: GRP_W]),
            .half (bit_half[k*GRP_W +: GRP_W]),
            .c_in (grp_carry[k]),
            .grp  (grp_pg[k]),
            .s    (sum[k*GRP_W +: GRP_W])
        );
    end

    cla16_lookahead #(.N(GRP_N)) u_la (
        .grp   (grp_pg),
        .cin   (cin),
        .carry (grp_carry)
    );

    assign cout = grp_carry[GRP_N];
endmodule

// File: rtl/cla16_checker.sv
module cla16_checker
    import cla16_pkg::*;
(
    input logic [ADD_W-1:0]    a,
    input logic [ADD_W-1:0]    b,
    input logic                cin,
    input logic [ADD_W-1:0]    sum,
    input logic                cout,
    input grp_pg_t [GRP_N-1:0] grp_pg,
    input logic [GRP_N:0]      grp_carry
);
    logic [ADD_W:0]   total;
    logic [GRP_W:0]   slice_nc;
    logic [ADD_W-1:0] either;
    logic [ADD_W:0]   low_sum;
    logic [ADD_W:0]   mask;

    always_comb begin
        total  = {1'b0, a} + {1'b0, b} + {{ADD_W{1'b0}}, cin};
        either = a | b;
        assert_total_R1: assert ({cout, sum} == total)
            else $error("R1/R2 total mismatch");
        assert_cout_R2: assert (cout == grp_carry[GRP_N])
            else $error("R2 cout differs from top group carry");
        for (int k = 0; k < GRP_N; k++) begin
            mask     = ({{ADD_W{1'b0}}, 1'b1} << (k * GRP_W)) - 1'b1;
            low_sum  = ({1'b0, a} & mask) + ({1'b0, b} & mask)
                       + {{ADD_W{1'b0}}, cin};
            slice_nc = {1'b0, a[k*GRP_W +: GRP_W]} + {1'b0, b[k*GRP_W +: GRP_W]};
            assert_grp_carry_R3: assert (grp_carry[k] == low_sum[k*GRP_W])
                else $error("R3 group carry %0d wrong", k);
            assert_grp_prop_R4: assert (grp_pg[k].prop == &either[k*GRP_W +: GRP_W])
                else $error("R4 group propagate %0d wrong", k);
            assert_grp_gen_R6: assert (grp_pg[k].gen == slice_nc[GRP_W])
                else $error("R6 group generate %0d wrong", k);
        end
    end
endmodule

bind cla16_adder cla16_checker u_chk (
    .a         (a),
    .b         (b),
    .cin       (cin),
    .sum       (sum),
    .cout      (cout),
    .grp_pg    (grp_pg),
    .grp_carry (grp_carry)
);

// File: tb/cla16_adder_test.sv
module cla16_adder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        cin = 1'b0;
    logic [15:0] sum;
    logic        cout;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    cla16_adder uut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

    task automatic apply(input logic [15:0] ta, input logic [15:0] tb_, input logic tc);
        @(negedge clk);
        a = ta; b = tb_; cin = tc;
        #2;
    endtask

    task automatic expect_out(input string req, input logic [15:0] es, input logic ec);
        checks++;
        if (sum !== es || cout !== ec) begin
            errors++;
            $display("FAIL %s: a=%h b=%h cin=%0d got sum=%h cout=%0d exp sum=%h cout=%0d",
                     req, a, b, cin, sum, cout, es, ec);
        end
    endtask

    task automatic test_zero();          // R5
        apply(16'h0000, 16'h0000, 1'b0);
        expect_out("R5", 16'h0000, 1'b0);
    endtask

    task automatic test_group_cross();   // R3
        apply(16'h000F, 16'h0001, 1'b0);
        expect_out("R3", 16'h0010, 1'b0);
        apply(16'h0F00, 16'h0100, 1'b0);
        expect_out("R3", 16'h1000, 1'b0);
        apply(16'h00F0, 16'h0010, 1'b0);
        expect_out("R3", 16'h0100, 1'b0);
        apply(16'hF000, 16'h1000, 1'b0);
        expect_out("R3", 16'h0000, 1'b1);
    endtask

    task automatic test_propagate();     // R4
        apply(16'hFFFF, 16'h0000, 1'b1);
        expect_out("R4", 16'h0000, 1'b1);
        apply(16'hAAAA, 16'h5555, 1'b1);
        expect_out("R4", 16'h0000, 1'b1);
        apply(16'hAAAA, 16'h5555, 1'b0);
        expect_out("R4", 16'hFFFF, 1'b0);
    endtask

    task automatic test_both_set();      // R6
        apply(16'hFFFF, 16'hFFFF, 1'b1);
        expect_out("R6", 16'hFFFF, 1'b1);
        apply(16'hFFFF, 16'hFFFF, 1'b0);
        expect_out("R6", 16'hFFFE, 1'b1);
    endtask

    task automatic test_example();       // R7
        apply(16'h1A33, 16'hE5EB, 1'b0);
        expect_out("R7", 16'h001E, 1'b1);
    endtask

    task automatic test_random(input int n);   // R1, R2, R8
        for (int i = 0; i < n; i++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            logic        rc;
            logic [16:0] tot;
            ra  = 16'($urandom);
            rb  = 16'($urandom);
            rc  = 1'($urandom);
            tot = {1'b0, ra} + {1'b0, rb} + {16'd0, rc};
            apply(ra, rb, rc);
            expect_out((i % 2 == 0) ? "R1" : "R2", tot[15:0], tot[16]);
            apply(rb, ra, rc);
            expect_out("R8", tot[15:0], tot[16]);
        end
    endtask

    initial begin
        #20_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout exp finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        test_zero();
        test_group_cross();
        test_propagate();
        test_both_set();
        test_example();
        test_random(300);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule